// File: doc/BRIEF.md
# Halt-Mode Wake-Up Controller

This block governs the low-power halt state of a small processor core. A one-cycle halt strobe from the core drops the system clock enable and freezes the core, so its memories, registers and pin states stay as they were. An always-on clock keeps the controller running while halted. It watches for a wake source and raises the clock enable again on the cycle after one arrives.

The wake sources are an external reset, a watchdog overflow, an interrupt request, and a falling edge on any port A pin that has its own wake enable set. On every wake the block reports what the core should do. A watchdog overflow during halt gives a warm-reset strobe. A port wake resumes at the next instruction. An interrupt wake takes the interrupt vector only when that interrupt is enabled and the stack has room; otherwise it also resumes at the next instruction. An interrupt whose request was already pending when halt was entered cannot wake the core. A watchdog overflow while running gives a full-reset strobe.

Top module: `halt_wake_ctrl`

## Requirements
- R1: A `halt_req` pulse while running (and with `wdt_ovf` low) clears `sys_clk_en` from the next clock edge onward.
- R2: While halted, further `halt_req` pulses have no effect, and with no wake source the block stays halted with no output strobes.
- R3: A falling edge on a port pin whose `pa_wake_en` bit is 1 wakes the block. `resume_valid` pulses with `resume_vector`=0 and `sys_clk_en` returns to 1 in the same cycle, three clock edges after the pin changes.
- R4: A falling edge on a pin whose wake enable is 0, or a rising edge on any pin, does not wake the block.
- R5: An interrupt wake with its `irq_en` bit set and `stack_full`=0 pulses `resume_valid` with `resume_vector`=1 and `vector_id` equal to the lowest-indexed waking request. `sys_clk_en` returns to 1 on the edge after the request is seen.
- R6: An interrupt wake with its enable bit clear, or with `stack_full`=1, pulses `resume_valid` with `resume_vector`=0. `vector_id` still names the request.
- R7: A request bit that was 1 on the edge that entered halt is excluded from waking and from `vector_id` selection for the rest of that halt.
- R8: `wdt_ovf` while halted pulses `warm_rst` for one cycle without `resume_valid` and re-enables the clock.
- R9: `wdt_ovf` while running pulses `full_rst` for one cycle and does not halt.
- R10: While `rst_n` is low, `sys_clk_en`=1, `full_rst`=1 and the other strobes are 0. `full_rst` stays 1 until the first clock edge after release. Reset during halt re-enables the clock at once.
- R11: When sources coincide in halt, the priority is watchdog over interrupt over port, and exactly one strobe is produced.
- R12: Port falling edges that happen while running are not remembered and cannot wake a later halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | External reset, asynchronous, active low |
| halt_req | input | 1 | Halt strobe from the core |
| pa_in | input | PA_W | Port A pin levels (asynchronous) |
| pa_wake_en | input | PA_W | Per-pin wake enable |
| irq_req | input | NIRQ | Interrupt request flags |
| irq_en | input | NIRQ | Interrupt enables |
| stack_full | input | 1 | Return stack has no free entry |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| sys_clk_en | output | 1 | System clock enable, 0 while halted |
| resume_valid | output | 1 | One-cycle pulse on a port or interrupt wake |
| resume_vector | output | 1 | With resume_valid: 1 = take interrupt call, 0 = next instruction |
| vector_id | output | IDW | Index of the interrupt that woke the core |
| warm_rst | output | 1 | One-cycle warm-reset strobe |
| full_rst | output | 1 | Full-reset strobe |

## Verification
A stuck or wrongly set halt flag shows at once on `sys_clk_en`: it either fails to drop on the edge after a halt strobe, or it stays low past the cycle in which a wake should have landed. A wrong interrupt snapshot shows as a premature wake or a wrong `vector_id` on the first interrupt raised during halt. A wrong synchronizer history shows as a wake that comes one cycle early or late, or as a phantom wake from a rising edge or from an edge seen while running. Every wake is compared as a strobe, decision and index triple in the cycle it appears.

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl #(
  parameter int PA_W = 8,
  parameter int NIRQ = 4,
  localparam int IDW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt_req,
  input  logic [PA_W-1:0] pa_in,
  input  logic [PA_W-1:0] pa_wake_en,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  input  logic            stack_full,
  input  logic            wdt_ovf,
  output logic            sys_clk_en,
  output logic            resume_valid,
  output logic            resume_vector,
  output logic [IDW-1:0]  vector_id,
  output logic            warm_rst,
  output logic            full_rst
);

  logic            halted;
  logic [PA_W-1:0] pa_s1, pa_s2, pa_prev;
  logic [NIRQ-1:0] irq_blk;
  logic [IDW-1:0]  pick_id;

  wire [PA_W-1:0] pa_fall  = pa_prev & ~pa_s2 & pa_wake_en;
  wire [NIRQ-1:0] irq_wake = irq_req & ~irq_blk;

  assign sys_clk_en = ~halted;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pa_s1   <= '1;
      pa_s2   <= '1;
      pa_prev <= '1;
    end else begin
      pa_s1   <= pa_in;
      pa_s2   <= pa_s1;
      pa_prev <= pa_s2;
    end

  always_comb begin
    pick_id = '0;
    for (int i = NIRQ - 1; i >= 0; i--)
      if (irq_wake[i]) pick_id = IDW'(i);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      halted        <= 1'b0;
      irq_blk       <= '0;
      resume_valid  <= 1'b0;
      resume_vector <= 1'b0;
      vector_id     <= '0;
      warm_rst      <= 1'b0;
      full_rst      <= 1'b1;
    end else begin
      resume_valid <= 1'b0;
      warm_rst     <= 1'b0;
      full_rst     <= 1'b0;
      if (!halted) begin
        if (wdt_ovf) full_rst <= 1'b1;
        else if (halt_req) begin
          halted  <= 1'b1;
          irq_blk <= irq_req;
        end
      end else if (wdt_ovf) begin
        halted   <= 1'b0;
        warm_rst <= 1'b1;
      end else if (|irq_wake) begin
        halted        <= 1'b0;
        resume_valid  <= 1'b1;
        resume_vector <= irq_en[pick_id] & ~stack_full;
        vector_id     <= pick_id;
      end else if (|pa_fall) begin
        halted        <= 1'b0;
        resume_valid  <= 1'b1;
        resume_vector <= 1'b0;
        vector_id     <= '0;
      end
    end

  a_r1_halt_stops_clock: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req && sys_clk_en && !wdt_ovf |=> !sys_clk_en);

  a_r2_idle_stays_halted: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_clk_en && !wdt_ovf && irq_wake == '0 && pa_fall == '0 |=> !sys_clk_en);

  a_r3_wake_runs_clock: assert property (@(posedge clk) disable iff (!rst_n)
    resume_valid || warm_rst |-> sys_clk_en);

  a_r5_vector_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    resume_valid && resume_vector |->
      ((($past(irq_en) >> vector_id) & NIRQ'(1)) != '0) && !$past(stack_full));

  a_r8_warm_from_halt: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |-> $past(!sys_clk_en) && $past(wdt_ovf));

  a_r11_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resume_valid, warm_rst, full_rst}));

endmodule

// File: tb/test_halt_wake_ctrl.sv
`timescale 1ns/1ps
module test_halt_wake_ctrl;
  localparam int PA_W = 8;
  localparam int NIRQ = 4;
  localparam int IDW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 1'b0;
  logic [PA_W-1:0] pa_in = '1;
  logic [PA_W-1:0] pa_wake_en = '0;
  logic [NIRQ-1:0] irq_req = '0;
  logic [NIRQ-1:0] irq_en = '0;
  logic stack_full = 1'b0;
  logic wdt_ovf = 1'b0;
  logic sys_clk_en, resume_valid, resume_vector, warm_rst, full_rst;
  logic [IDW-1:0] vector_id;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int    q_exp[$];
  string q_req[$];

  halt_wake_ctrl #(.PA_W(PA_W), .NIRQ(NIRQ)) i_halt_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .pa_in(pa_in),
    .pa_wake_en(pa_wake_en), .irq_req(irq_req), .irq_en(irq_en),
    .stack_full(stack_full), .wdt_ovf(wdt_ovf), .sys_clk_en(sys_clk_en),
    .resume_valid(resume_valid), .resume_vector(resume_vector),
    .vector_id(vector_id), .warm_rst(warm_rst), .full_rst(full_rst));

  always #2.5 clk = ~clk;

  task automatic check_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // kind: 1 resume, 2 warm, 3 full; code = kind*100 + vector*10 + id
  task automatic expect_ev(int kind, int vec, int id, string req);
    q_exp.push_back(kind * 100 + vec * 10 + id);
    q_req.push_back(req);
  endtask

  task automatic enter_halt(string req);
    halt_req = 1'b1;
    tick(1);
    halt_req = 1'b0;
    check_eq(req, sys_clk_en, 0);
  endtask

  task automatic wdt_wake(string req);
    expect_ev(2, 0, 0, req);
    wdt_ovf = 1'b1;
    tick(1);
    wdt_ovf = 1'b0;
    check_eq(req, sys_clk_en, 1);
    tick(2);
  endtask

  always @(negedge clk) begin
    if (rst_n && (resume_valid || warm_rst || full_rst)) begin
      int act;
      act = (resume_valid ? 100 : warm_rst ? 200 : 300) +
            (resume_valid ? (int'(resume_vector) * 10 + int'(vector_id)) : 0);
      if (q_exp.size() == 0) begin
        checks++; fails++;
        $display("FAIL unexpected strobe actual=%0d expected=none", act);
      end else begin
        int e;
        string r;
        e = q_exp.pop_front();
        r = q_req.pop_front();
        check_eq(r, act, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      done = 1;
      $finish;
    end
  end

  initial begin
    // R10 reset state
    #3;
    check_eq("R10 clk_en in reset", sys_clk_en, 1);
    check_eq("R10 full_rst in reset", full_rst, 1);
    check_eq("R10 strobes in reset", resume_valid | warm_rst, 0);
    tick(2);
    expect_ev(3, 0, 0, "R10 full after release");
    rst_n = 1'b1;
    tick(3);
    pa_wake_en = 8'b0000_0001;
    irq_en = '1;

    // R3 port wake with latency
    enter_halt("R1 halt entry");
    pa_in[0] = 1'b0;
    tick(2);
    check_eq("R3 still halted before latency", sys_clk_en, 0);
    expect_ev(1, 0, 0, "R3 port wake");
    tick(1);
    check_eq("R3 clock back", sys_clk_en, 1);
    pa_in[0] = 1'b1;
    tick(4);

    // R4 and R2: disabled pin, rising edge, extra halt strobe
    enter_halt("R1 halt entry 2");
    pa_in[1] = 1'b0;
    tick(5);
    check_eq("R4 disabled pin no wake", sys_clk_en, 0);
    pa_in[1] = 1'b1;
    tick(5);
    check_eq("R4 rising edge no wake", sys_clk_en, 0);
    halt_req = 1'b1;
    tick(1);
    halt_req = 1'b0;
    tick(4);
    check_eq("R2 stays halted", sys_clk_en, 0);
    wdt_wake("R8 warm wake");

    // R5 vectored interrupt, lowest index
    enter_halt("R1 halt entry 3");
    expect_ev(1, 1, 1, "R5 vector to lowest");
    irq_req = 4'b0110;
    tick(1);
    check_eq("R5 clock back", sys_clk_en, 1);
    irq_req = '0;
    tick(2);

    // R6 disabled interrupt
    enter_halt("R1 halt entry 4");
    irq_en = 4'b0000;
    expect_ev(1, 0, 2, "R6 disabled irq resumes");
    irq_req = 4'b0100;
    tick(1);
    irq_req = '0;
    irq_en = '1;
    tick(2);

    // R6 stack full
    enter_halt("R1 halt entry 5");
    stack_full = 1'b1;
    expect_ev(1, 0, 3, "R6 stack full resumes");
    irq_req = 4'b1000;
    tick(1);
    irq_req = '0;
    stack_full = 1'b0;
    tick(2);

    // R7 pending before halt is excluded
    irq_req = 4'b0001;
    tick(1);
    enter_halt("R1 halt entry 6");
    tick(5);
    check_eq("R7 pending irq no wake", sys_clk_en, 0);
    expect_ev(1, 1, 2, "R7 fresh irq picked over blocked");
    irq_req = 4'b0101;
    tick(1);
    irq_req = '0;
    tick(2);

    // R9 watchdog while running
    expect_ev(3, 0, 0, "R9 full reset strobe");
    wdt_ovf = 1'b1;
    tick(1);
    wdt_ovf = 1'b0;
    check_eq("R9 no halt", sys_clk_en, 1);
    tick(2);

    // R11 priority: watchdog over interrupt
    enter_halt("R1 halt entry 7");
    expect_ev(2, 0, 0, "R11 watchdog beats irq");
    wdt_ovf = 1'b1;
    irq_req = 4'b0010;
    tick(1);
    wdt_ovf = 1'b0;
    irq_req = '0;
    tick(2);

    // R11 priority: interrupt over port
    enter_halt("R1 halt entry 8");
    irq_en = '0;
    pa_in[0] = 1'b0;
    tick(2);
    expect_ev(1, 0, 1, "R11 irq beats port");
    irq_req = 4'b0010;
    tick(1);
    irq_req = '0;
    irq_en = '1;
    pa_in[0] = 1'b1;
    tick(4);

    // R12 edge while running is forgotten
    pa_in[0] = 1'b0;
    tick(5);
    enter_halt("R1 halt entry 9");
    tick(5);
    check_eq("R12 old edge no wake", sys_clk_en, 0);
    wdt_wake("R8 warm wake 2");
    pa_in[0] = 1'b1;
    tick(4);

    // R10 reset during halt
    enter_halt("R1 halt entry 10");
    rst_n = 1'b0;
    #1;
    check_eq("R10 reset restores clock", sys_clk_en, 1);
    tick(1);
    expect_ev(3, 0, 0, "R10 full after release 2");
    rst_n = 1'b1;
    tick(4);

    check_eq("R3 all expected strobes seen", q_exp.size(), 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule